// File: doc/BRIEF.md
# Condition Code Register with Right-Shift Flag Unit

This block holds the eight-bit condition code register of a small processor core and the right shifter whose results set its arithmetic flags. The shifter moves a 16-bit operand right by 0 to 15 places, either logically (zero fill) or arithmetically (sign fill). Its result is available on the same cycle. The carry, sticky, negative and zero flags that describe the shift are stored in the register at the next clock edge.

The same register carries two control bits. The interrupt-enable bit gates every hardware interrupt request line, while a software interrupt request is passed through regardless of it. The stack-select bit chooses between the user stack pointer and the system stack pointer and drives a dedicated select output. Reset and interrupt acceptance force both control bits to known values. The whole byte can also be read, and written from a data bus.

Bit positions, with 0 the least significant: C carry = 0, V overflow = 1, Z zero = 2, N negative = 3, T sticky = 4, S stack select = 5, I interrupt enable = 6. Bit 7 is unused.

Top module: `ccr_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `rd_data` reads 0x20: I=0 (bit 6), S=1 (bit 5), and T, N, Z, V, C all 0.
- R2: Bit 7 of `rd_data` always reads 0, and writing a 1 to bit 7 has no effect on any bit.
- R3: With `wr_en` high, bits 6..0 of `wr_data` appear on `rd_data` after the next rising clock edge. When no write, shift or interrupt acceptance occurs, `rd_data` holds its value.
- R4: With `shift_arith` low, `shift_result` is `shift_operand` shifted right by `shift_amt`, with the vacated high bits filled with 0, on the same cycle.
- R5: With `shift_arith` high, the vacated high bits of `shift_result` are filled with bit 15 of `shift_operand`.
- R6: After a shift, C (bit 0) holds the last bit shifted out, and T (bit 4) is 1 exactly when any bit shifted out was 1. A shift amount of 0 clears both C and T.
- R7: After a shift, N (bit 3) equals bit 15 of the result and Z (bit 2) is 1 exactly when the result is zero. V (bit 1) is not changed by a shift.
- R8: `irq_accept` sets S (bit 5) at the next edge. When it coincides with a write, S is still set to 1 whatever `wr_data[5]` holds.
- R9: When a shift and a write occur in the same cycle, T, N, Z and C take the shift values, and I, S and V take the written values.
- R10: `hw_irq_en` equals `hw_irq_req` when I is 1 and is all zeros when I is 0. `sw_irq_en` always follows `sw_irq_req`. `sp_sel` always equals S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the register from `wr_data` |
| wr_data | input | 8 | Byte to write; bit 7 is ignored |
| rd_data | output | 8 | Current register contents, bit 7 reads 0 |
| shift_valid | input | 1 | A right shift executes this cycle and updates flags |
| shift_arith | input | 1 | 1 = arithmetic fill, 0 = logical fill |
| shift_amt | input | 4 | Shift distance, 0 to 15 |
| shift_operand | input | 16 | Value to shift |
| shift_result | output | 16 | Shifted value, combinational |
| irq_accept | input | 1 | An interrupt is being taken this cycle |
| hw_irq_req | input | 4 | Hardware interrupt request lines |
| sw_irq_req | input | 1 | Software interrupt request |
| hw_irq_en | output | 4 | Requests passed by the interrupt-enable bit |
| sw_irq_en | output | 1 | Software request, never masked |
| sp_sel | output | 1 | 0 = user stack pointer, 1 = system stack pointer |

## Verification
The assertions assume that every control input holds a known 0 or 1 at each rising edge once reset is released, and that `shift_amt` and `shift_operand` are known whenever `shift_valid` is high. Write, shift and interrupt acceptance may occur together in any combination. The bench changes inputs only on the falling edge and holds them at 0 while reset is low. Its sequence deliberately stacks a write on top of a shift and on top of an interrupt acceptance, so that the priority rules are exercised and not only isolated events.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    // Seven live bits, declared from bit 6 down to bit 0 of the byte.
    typedef struct packed {
        logic ien;    // bit 6: hardware interrupt enable
        logic ssel;   // bit 5: stack select
        logic stk;    // bit 4: sticky
        logic neg;    // bit 3
        logic zer;    // bit 2
        logic ovf;    // bit 1
        logic cry;    // bit 0
    } ccr_flags_t;

    localparam ccr_flags_t CCR_RESET = '{ien: 1'b0, ssel: 1'b1, stk: 1'b0,
                                         neg: 1'b0, zer: 1'b0, ovf: 1'b0,
                                         cry: 1'b0};

    typedef struct packed {
        logic cry;
        logic stk;
        logic neg;
        logic zer;
    } shift_flags_t;

endpackage

// File: rtl/ccr_rshift.sv
module ccr_rshift
    import ccr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amt,
    input  logic              arith,
    output logic [DATA_W-1:0] result,
    output shift_flags_t      flags
);

    logic              fill_bit;
    logic [DATA_W-1:0] plain_shift;
    logic              lost_any;

    always_comb begin
        fill_bit    = arith & operand[DATA_W-1];
        plain_shift = operand >> amt;
        lost_any    = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            if (k >= DATA_W - int'(amt)) begin
                result[k] = fill_bit;
            end else begin
                result[k] = plain_shift[k];
            end
            if (k < int'(amt)) begin
                lost_any = lost_any | operand[k];
            end
        end
    end

    always_comb begin
        if (amt == '0) begin
            flags.cry = 1'b0;
            flags.stk = 1'b0;
        end else begin
            flags.cry = operand[amt - 1'b1];
            flags.stk = lost_any;
        end
        flags.neg = result[DATA_W-1];
        flags.zer = (result == '0);
    end

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate #(
    parameter int NUM_HW_IRQ = 4
) (
    input  logic                  ien,
    input  logic [NUM_HW_IRQ-1:0] hw_req,
    input  logic                  sw_req,
    output logic [NUM_HW_IRQ-1:0] hw_grant,
    output logic                  sw_grant
);

    for (genvar g = 0; g < NUM_HW_IRQ; g++) begin : g_line
        assign hw_grant[g] = hw_req[g] & ien;
    end

    assign sw_grant = sw_req;

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_HW_IRQ = 4,
    localparam int AMT_W     = $clog2(DATA_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic                  shift_valid,
    input  logic                  shift_arith,
    input  logic [AMT_W-1:0]      shift_amt,
    input  logic [DATA_W-1:0]     shift_operand,
    output logic [DATA_W-1:0]     shift_result,
    input  logic                  irq_accept,
    input  logic [NUM_HW_IRQ-1:0] hw_irq_req,
    input  logic                  sw_irq_req,
    output logic [NUM_HW_IRQ-1:0] hw_irq_en,
    output logic                  sw_irq_en,
    output logic                  sp_sel
);

    ccr_flags_t   ccr_d, ccr_q;
    shift_flags_t sh_flags;

    ccr_rshift #(.DATA_W(DATA_W)) u_rshift (
        .operand (shift_operand),
        .amt     (shift_amt),
        .arith   (shift_arith),
        .result  (shift_result),
        .flags   (sh_flags)
    );

    ccr_irq_gate #(.NUM_HW_IRQ(NUM_HW_IRQ)) u_irq_gate (
        .ien      (ccr_q.ien),
        .hw_req   (hw_irq_req),
        .sw_req   (sw_irq_req),
        .hw_grant (hw_irq_en),
        .sw_grant (sw_irq_en)
    );

    // Next state: write, then shift flags on top, then interrupt acceptance on S.
    always_comb begin
        ccr_d = ccr_q;
        if (wr_en) begin
            ccr_d = ccr_flags_t'(wr_data[6:0]);
        end
        if (shift_valid) begin
            ccr_d.cry = sh_flags.cry;
            ccr_d.stk = sh_flags.stk;
            ccr_d.neg = sh_flags.neg;
            ccr_d.zer = sh_flags.zer;
        end
        if (irq_accept) begin
            ccr_d.ssel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr_q <= CCR_RESET;
        end else begin
            ccr_q <= ccr_d;
        end
    end

    assign rd_data = {1'b0, ccr_q};
    assign sp_sel  = ccr_q.ssel;

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !shift_valid && !irq_accept) |=> $stable(rd_data));

    p_wr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !shift_valid && !irq_accept) |=> rd_data[6:0] == $past(wr_data[6:0]));

    p_zero_amt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid && shift_amt == '0) |=> (rd_data[4] == 1'b0 && rd_data[0] == 1'b0));

    p_zflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_valid |=> rd_data[2] == ($past(shift_result) == '0));

    p_irq_sets_s_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> (rd_data[5] && sp_sel));

    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[6]) |=> hw_irq_en == '0);

endmodule

// File: tb/ccr_unit_tb_top.sv
`timescale 1ns/1ps
module ccr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        shift_valid = 1'b0;
    logic        shift_arith = 1'b0;
    logic [3:0]  shift_amt = '0;
    logic [15:0] shift_operand = '0;
    logic [15:0] shift_result;
    logic        irq_accept = 1'b0;
    logic [3:0]  hw_irq_req = '0;
    logic        sw_irq_req = 1'b0;
    logic [3:0]  hw_irq_en;
    logic        sw_irq_en;
    logic        sp_sel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h20;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    ccr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .shift_valid(shift_valid), .shift_arith(shift_arith), .shift_amt(shift_amt),
        .shift_operand(shift_operand), .shift_result(shift_result),
        .irq_accept(irq_accept), .hw_irq_req(hw_irq_req), .sw_irq_req(sw_irq_req),
        .hw_irq_en(hw_irq_en), .sw_irq_en(sw_irq_en), .sp_sel(sp_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares the register against the item queued on the previous falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'h0, rd_data}, {24'h0, e});
        end
    end

    // Driver: applies one cycle of stimulus, checks combinational outputs, queues the register value.
    task automatic step(input logic we, input logic [7:0] wd, input logic sv, input logic sa,
                        input logic [3:0] amt, input logic [15:0] op, input logic ia,
                        input logic [3:0] hw, input logic sw, input string tag);
        logic [15:0] res;
        logic        cy, st;
        logic [7:0]  nx;
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = we; wr_data = wd; shift_valid = sv; shift_arith = sa;
        shift_amt = amt; shift_operand = op; irq_accept = ia;
        hw_irq_req = hw; sw_irq_req = sw;
        #1;
        if (sa) res = 16'($signed(op) >>> amt);
        else    res = op >> amt;
        st = (amt != 0) && ((op & ((16'd1 << amt) - 16'd1)) != 16'd0);
        cy = (amt != 0) ? op[amt - 4'd1] : 1'b0;
        check({tag, " shift_result (R4/R5)"}, {16'h0, shift_result}, {16'h0, res});
        check("R10 hw_irq_en", {28'h0, hw_irq_en}, {28'h0, (model[6] ? hw : 4'h0)});
        check("R10 sw_irq_en", {31'h0, sw_irq_en}, {31'h0, sw});
        check("R10 sp_sel", {31'h0, sp_sel}, {31'h0, model[5]});
        nx = model;
        if (we) nx[6:0] = wd[6:0];
        if (sv) begin
            nx[0] = cy; nx[4] = st; nx[3] = res[15]; nx[2] = (res == 16'h0);
        end
        if (ia) nx[5] = 1'b1;
        nx[7] = 1'b0;
        model = nx;
        exp_q.push_back(nx);
        tag_q.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 0; shift_valid = 0; irq_accept = 0; hw_irq_req = 0; sw_irq_req = 0;
        #1;
        model = 8'h20;
        exp_q.push_back(8'h20);
        tag_q.push_back("R1 reset value");
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", {24'h0, rd_data}, 32'h20);
        check("R1 sp_sel in reset", {31'h0, sp_sel}, 32'h1);
        step(0, 8'h00, 0, 0, 0, 16'h0, 0, 4'h0, 0, "R1 first cycle");
        step(1, 8'hFF, 0, 0, 0, 16'h0, 0, 4'h0, 0, "R2 R3 write with bit7");
        step(0, 8'h00, 0, 0, 0, 16'h0, 0, 4'hF, 1, "R10 enabled");
        step(0, 8'h00, 1, 0, 4'd1, 16'h8001, 0, 4'h0, 0, "R4 R6 logical by 1");
        step(0, 8'h00, 1, 1, 4'd15, 16'h8000, 0, 4'h0, 0, "R5 arith by 15");
        step(0, 8'h00, 1, 0, 4'd4, 16'h00F0, 0, 4'h0, 0, "R6 no ones lost");
        step(0, 8'h00, 1, 0, 4'd8, 16'h00F0, 0, 4'h0, 0, "R7 zero result");
        step(0, 8'h00, 1, 1, 4'd0, 16'hFFFF, 0, 4'h0, 0, "R6 amount zero");
        step(1, 8'h00, 0, 0, 0, 16'h0, 1, 4'h0, 0, "R8 accept beats write");
        step(0, 8'h00, 0, 0, 0, 16'h0, 0, 4'hF, 1, "R10 masked");
        step(1, 8'h7F, 1, 0, 4'd1, 16'h0002, 0, 4'h0, 0, "R9 shift beats write");
        step(1, 8'h80, 0, 0, 0, 16'h0, 0, 4'h0, 0, "R2 bit7 only write");
        step(0, 8'h00, 0, 0, 0, 16'h0, 1, 4'h5, 0, "R8 accept alone");
        step(1, 8'h42, 0, 0, 0, 16'h0, 0, 4'h0, 0, "R3 set I and V");
        step(0, 8'h00, 1, 1, 4'd3, 16'h4000, 0, 4'hA, 0, "R7 V kept by shift");
        for (int a = 0; a < 16; a++) begin
            step(0, 8'h00, 1, 0, 4'(a), 16'hB5A3, 0, 4'h0, 0, "R4 R6 R7 logical sweep");
            step(0, 8'h00, 1, 1, 4'(a), 16'hB5A3, 0, 4'h0, 0, "R5 R6 R7 arith sweep");
            step(0, 8'h00, 1, 1, 4'(a), 16'h7FFE, 0, 4'h3, 1, "R5 R6 positive sweep");
        end
        step(0, 8'h00, 0, 0, 0, 16'h0, 0, 4'h0, 0, "R3 idle hold");
        do_reset();
        step(0, 8'h00, 0, 0, 0, 16'h0, 0, 4'hF, 0, "R1 after mid reset");
        @(negedge clk);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule